// File: doc/BRIEF.md
# ADC Sample Averaging Accumulator

This block sits behind a continuously converting 8-bit ADC. Each pulse of a sample strobe delivers one conversion. The block keeps the most recent sample, and it keeps the smallest and largest samples seen since the last min/max clear. A second strobe, once per second, closes a measurement window.

Inside a window, samples are summed into a positive sum and a negative sum. In unsigned mode every sample goes to the positive sum. In offset-signed mode the mid-scale code is removed first, and each sample goes to the side its sign selects. At each window close, each sum is divided by 64 and latched as a read-only average. The averages are then folded into two 32-bit running totals. Software can overwrite the totals through a write port.

Three configuration inputs control how the totals build up. One selects signed handling. One routes both averages into the positive total. One freezes both totals.

Top module: `adc_avg_accum`

## Requirements
- R1: On a cycle with `sample_tick` high, `inst_sample` shows `sample_in` from the next cycle. On all other cycles it holds its value.
- R2: `min_sample` and `max_sample` track the smallest and largest sample accepted since the last clear. `mm_clear` sets them to 0xFF and 0x00 and wins over a sample in the same cycle.
- R3: With `cfg_signed` low, the full sample code is added to the positive sum, and the negative sum receives nothing.
- R4: With `cfg_signed` high, 128 is subtracted from the sample. A result above zero is added to the positive sum, and the magnitude of a result below zero is added to the negative sum. Code 128 adds nothing to either sum.
- R5: Each window sum is 20 bits wide. At `second_tick` each average becomes its sum shifted right by 6 (the top 14 bits, zero-extended to 16). Between strobes the averages hold.
- R6: `second_tick` restarts both sums. A sample accepted in the same cycle as the strobe counts toward the new window.
- R7: With `cfg_group` low, at `second_tick` each total grows by the average latched from its own sum.
- R8: With `cfg_group` high, at `second_tick` the positive total grows by both averages, and the negative total is unchanged.
- R9: With `cfg_stop` high, neither total changes at `second_tick`, while the averages and the instantaneous sample still update.
- R10: `tot_wr_pos` / `tot_wr_neg` load `tot_wr_data` into the positive / negative total on the next cycle. A write wins over an accumulation in the same cycle.
- R11: The totals wrap modulo 2^32.
- R12: After reset the sample, the averages and the totals read zero, `min_sample` reads 0xFF and `max_sample` reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_tick | input | 1 | Strobe: `sample_in` holds a new conversion |
| sample_in | input | 8 | ADC conversion code |
| second_tick | input | 1 | Window close strobe, once per second |
| cfg_signed | input | 1 | 1 = offset-signed handling, 0 = unsigned |
| cfg_group | input | 1 | 1 = both averages go to the positive total |
| cfg_stop | input | 1 | 1 = totals frozen |
| mm_clear | input | 1 | Reset minimum to 0xFF and maximum to 0x00 |
| tot_wr_pos | input | 1 | Write `tot_wr_data` to the positive total |
| tot_wr_neg | input | 1 | Write `tot_wr_data` to the negative total |
| tot_wr_data | input | 32 | Data for total writes |
| inst_sample | output | 8 | Most recent accepted sample |
| min_sample | output | 8 | Smallest sample since clear |
| max_sample | output | 8 | Largest sample since clear |
| avg_pos | output | 16 | Positive-side average of the last window |
| avg_neg | output | 16 | Negative-side average of the last window |
| tot_pos | output | 32 | Positive running total |
| tot_neg | output | 32 | Negative running total |

## Verification
The bench drives a full-scale window of 4000 samples of 0xFF, which must reach 15937 without overflow. A sum one bit too narrow, or a wrong shift, would show there. It also places a sample and a total write in the same cycle as the strobe. A design that dropped that sample, or let the accumulation beat the write, would leave the next average or the total wrong.

In signed mode, codes above, below and exactly at 128 are mixed together. A design with an off-by-one in the split would leak code 128, or code 127, into the wrong sum. Group, stop and modulo-2^32 wrap are each checked on the totals. A clear together with a sample must still leave the min/max pair at 0xFF/0x00.

// File: rtl/adc_avg_pkg.sv
package adc_avg_pkg;
   // channel indices of the two window sums and totals
   localparam int NUM_SIDES = 2;
   localparam int SIDE_POS  = 0;
   localparam int SIDE_NEG  = 1;
endpackage

// File: rtl/adc_sample_split.sv
module adc_sample_split #(
   parameter int SAMPLE_W = 8
) (
   input  logic [SAMPLE_W-1:0] sample,
   input  logic                signed_mode,
   output logic [SAMPLE_W-1:0] pos_part,
   output logic [SAMPLE_W-1:0] neg_part
);
   localparam logic [SAMPLE_W-1:0] MID = {1'b1, {(SAMPLE_W-1){1'b0}}};

   generate
      if (SAMPLE_W < 2) begin : g_bad_width
         $error("adc_sample_split: SAMPLE_W must be at least 2");
      end
   endgenerate

   always_comb begin
      pos_part = '0;
      neg_part = '0;
      if (!signed_mode) begin
         pos_part = sample;
      end else if (sample > MID) begin
         pos_part = sample - MID;
      end else if (sample < MID) begin
         neg_part = MID - sample;
      end
   end
endmodule

// File: rtl/adc_window_sum.sv
module adc_window_sum #(
   parameter int IN_W  = 8,
   parameter int SUM_W = 20,
   parameter int SHIFT = 6,
   parameter int AVG_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             add_en,
   input  logic [IN_W-1:0]  add_val,
   input  logic             close,
   output logic [AVG_W-1:0] scaled,
   output logic [AVG_W-1:0] avg_q
);
   localparam int KEEP = SUM_W - SHIFT;

   generate
      if (KEEP > AVG_W) begin : g_avg_too_narrow
         $error("adc_window_sum: AVG_W too small for SUM_W - SHIFT");
      end
      if (IN_W > SUM_W) begin : g_sum_too_narrow
         $error("adc_window_sum: SUM_W must cover IN_W");
      end
   endgenerate

   logic [SUM_W-1:0] sum_q;
   logic [SUM_W-1:0] addend;

   assign addend = add_en ? SUM_W'(add_val) : '0;
   assign scaled = AVG_W'(sum_q >> SHIFT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum_q <= '0;
         avg_q <= '0;
      end else if (close) begin
         sum_q <= addend;
         avg_q <= scaled;
      end else begin
         sum_q <= sum_q + addend;
      end
   end

   // average only moves on a window close
   p_avg_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !close |=> $stable(avg_q));
   // a window close restarts the sum from the coincident sample only
   p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
      close && !add_en |=> sum_q == '0);
endmodule

// File: rtl/adc_total_acc.sv
module adc_total_acc #(
   parameter int TOT_W = 32,
   parameter int AVG_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc_en,
   input  logic [AVG_W-1:0] add_a,
   input  logic [AVG_W-1:0] add_b,
   input  logic             use_b,
   input  logic             wr_en,
   input  logic [TOT_W-1:0] wr_data,
   output logic [TOT_W-1:0] total_q
);
   generate
      if (TOT_W < AVG_W) begin : g_total_too_narrow
         $error("adc_total_acc: TOT_W must cover AVG_W");
      end
   endgenerate

   logic [TOT_W-1:0] inc_sum;
   assign inc_sum = TOT_W'(add_a) + (use_b ? TOT_W'(add_b) : '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         total_q <= '0;
      else if (wr_en)
         total_q <= wr_data;
      else if (inc_en)
         total_q <= total_q + inc_sum;
   end

   // write beats accumulation
   p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> total_q == $past(wr_data));
   p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en && !inc_en |=> $stable(total_q));
endmodule

// File: rtl/adc_minmax.sv
module adc_minmax #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         upd,
   input  logic [W-1:0] val,
   output logic [W-1:0] min_q,
   output logic [W-1:0] max_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         min_q <= '1;
         max_q <= '0;
      end else if (clear) begin
         min_q <= '1;
         max_q <= '0;
      end else if (upd) begin
         if (val < min_q) min_q <= val;
         if (val > max_q) max_q <= val;
      end
   end

   p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (min_q == '1) && (max_q == '0));
   p_min_mono_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !clear |=> (min_q <= $past(min_q)) && (max_q >= $past(max_q)));
endmodule

// File: rtl/adc_avg_accum.sv
module adc_avg_accum
   import adc_avg_pkg::*;
#(
   parameter int SAMPLE_W = 8,
   parameter int SUM_W    = 20,
   parameter int SHIFT    = 6,
   parameter int AVG_W    = 16,
   parameter int TOT_W    = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sample_tick,
   input  logic [SAMPLE_W-1:0] sample_in,
   input  logic                second_tick,
   input  logic                cfg_signed,
   input  logic                cfg_group,
   input  logic                cfg_stop,
   input  logic                mm_clear,
   input  logic                tot_wr_pos,
   input  logic                tot_wr_neg,
   input  logic [TOT_W-1:0]    tot_wr_data,
   output logic [SAMPLE_W-1:0] inst_sample,
   output logic [SAMPLE_W-1:0] min_sample,
   output logic [SAMPLE_W-1:0] max_sample,
   output logic [AVG_W-1:0]    avg_pos,
   output logic [AVG_W-1:0]    avg_neg,
   output logic [TOT_W-1:0]    tot_pos,
   output logic [TOT_W-1:0]    tot_neg
);
   logic [SAMPLE_W-1:0] part   [NUM_SIDES];
   logic [AVG_W-1:0]    scaled [NUM_SIDES];
   logic [AVG_W-1:0]    avg    [NUM_SIDES];
   logic [TOT_W-1:0]    total  [NUM_SIDES];
   logic                wr_sel [NUM_SIDES];

   assign wr_sel[SIDE_POS] = tot_wr_pos;
   assign wr_sel[SIDE_NEG] = tot_wr_neg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         inst_sample <= '0;
      else if (sample_tick)
         inst_sample <= sample_in;
   end

   adc_sample_split #(.SAMPLE_W(SAMPLE_W)) u_split (
      .sample      (sample_in),
      .signed_mode (cfg_signed),
      .pos_part    (part[SIDE_POS]),
      .neg_part    (part[SIDE_NEG])
   );

   adc_minmax #(.W(SAMPLE_W)) u_minmax (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (mm_clear),
      .upd   (sample_tick),
      .val   (sample_in),
      .min_q (min_sample),
      .max_q (max_sample)
   );

   for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
      adc_window_sum #(
         .IN_W(SAMPLE_W), .SUM_W(SUM_W), .SHIFT(SHIFT), .AVG_W(AVG_W)
      ) u_sum (
         .clk     (clk),
         .rst_n   (rst_n),
         .add_en  (sample_tick),
         .add_val (part[s]),
         .close   (second_tick),
         .scaled  (scaled[s]),
         .avg_q   (avg[s])
      );

      // the positive total may take both averages; the negative one only its own
      logic side_inc;
      logic side_use_b;
      if (s == SIDE_POS) begin : g_pos_route
         assign side_inc   = second_tick && !cfg_stop;
         assign side_use_b = cfg_group;
      end else begin : g_neg_route
         assign side_inc   = second_tick && !cfg_stop && !cfg_group;
         assign side_use_b = 1'b0;
      end

      adc_total_acc #(.TOT_W(TOT_W), .AVG_W(AVG_W)) u_total (
         .clk     (clk),
         .rst_n   (rst_n),
         .inc_en  (side_inc),
         .add_a   (scaled[s]),
         .add_b   (scaled[SIDE_NEG]),
         .use_b   (side_use_b),
         .wr_en   (wr_sel[s]),
         .wr_data (tot_wr_data),
         .total_q (total[s])
      );
   end

   assign avg_pos = avg[SIDE_POS];
   assign avg_neg = avg[SIDE_NEG];
   assign tot_pos = total[SIDE_POS];
   assign tot_neg = total[SIDE_NEG];

   p_inst_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_tick |=> $stable(inst_sample));
   p_inst_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
      sample_tick |=> inst_sample == $past(sample_in));
   p_unsigned_neg_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_signed |-> part[SIDE_NEG] == '0);
   p_one_side_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !((|part[SIDE_POS]) && (|part[SIDE_NEG])));
   p_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_stop && !tot_wr_pos && !tot_wr_neg |=> $stable(tot_pos) && $stable(tot_neg));
   p_group_neg_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_group && !tot_wr_neg |=> $stable(tot_neg));
endmodule

// File: tb/adc_avg_accum_test.sv
module adc_avg_accum_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sample_tick = 1'b0;
   logic [7:0]  sample_in = '0;
   logic        second_tick = 1'b0;
   logic        cfg_signed = 1'b0;
   logic        cfg_group = 1'b0;
   logic        cfg_stop = 1'b0;
   logic        mm_clear = 1'b0;
   logic        tot_wr_pos = 1'b0;
   logic        tot_wr_neg = 1'b0;
   logic [31:0] tot_wr_data = '0;
   logic [7:0]  inst_sample, min_sample, max_sample;
   logic [15:0] avg_pos, avg_neg;
   logic [31:0] tot_pos, tot_neg;

   int errors = 0;
   int checks = 0;

   // bench-side expectations
   logic [19:0] sp = '0, sn = '0;
   logic [31:0] tp = '0, tn = '0;
   logic [31:0] eap = '0, ean = '0;
   logic [7:0]  emin = 8'hFF, emax = 8'h00;

   always #10 clk = ~clk;

   adc_avg_accum uut (
      .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .sample_in(sample_in),
      .second_tick(second_tick), .cfg_signed(cfg_signed), .cfg_group(cfg_group),
      .cfg_stop(cfg_stop), .mm_clear(mm_clear), .tot_wr_pos(tot_wr_pos),
      .tot_wr_neg(tot_wr_neg), .tot_wr_data(tot_wr_data), .inst_sample(inst_sample),
      .min_sample(min_sample), .max_sample(max_sample), .avg_pos(avg_pos),
      .avg_neg(avg_neg), .tot_pos(tot_pos), .tot_neg(tot_neg)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic model_add(input logic [7:0] s);
      if (!cfg_signed) sp = sp + 20'(s);
      else if (s > 8'd128) sp = sp + 20'(s - 8'd128);
      else if (s < 8'd128) sn = sn + 20'(8'd128 - s);
   endtask

   task automatic send(input logic [7:0] s);
      sample_in = s;
      sample_tick = 1'b1;
      model_add(s);
      if (!mm_clear) begin
         if (s < emin) emin = s;
         if (s > emax) emax = s;
      end
      @(negedge clk);
      sample_tick = 1'b0;
   endtask

   task automatic send_n(input logic [7:0] s, input int n);
      for (int i = 0; i < n; i++) send(s);
   endtask

   // window close, optionally with a coincident sample and/or total write
   task automatic strobe(input string tag, input bit with_s, input logic [7:0] s,
                         input bit wp, input bit wn, input logic [31:0] wd);
      eap = 32'(sp >> 6);
      ean = 32'(sn >> 6);
      if (!cfg_stop) begin
         if (cfg_group) tp = tp + eap + ean;
         else begin
            tp = tp + eap;
            tn = tn + ean;
         end
      end
      if (wp) tp = wd;
      if (wn) tn = wd;
      sp = '0;
      sn = '0;
      tot_wr_pos = wp;
      tot_wr_neg = wn;
      tot_wr_data = wd;
      second_tick = 1'b1;
      if (with_s) send(s);
      else @(negedge clk);
      second_tick = 1'b0;
      tot_wr_pos = 1'b0;
      tot_wr_neg = 1'b0;
      chk({tag, " avg_pos"}, 32'(avg_pos), eap);
      chk({tag, " avg_neg"}, 32'(avg_neg), ean);
      chk({tag, " tot_pos"}, tot_pos, tp);
      chk({tag, " tot_neg"}, tot_neg, tn);
   endtask

   task automatic t_reset;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R12 inst", 32'(inst_sample), 0);
      chk("R12 min", 32'(min_sample), 32'hFF);
      chk("R12 max", 32'(max_sample), 0);
      chk("R12 avg_pos", 32'(avg_pos), 0);
      chk("R12 tot_neg", tot_neg, 0);
   endtask

   task automatic t_minmax;
      send(8'd90); send(8'd17); send(8'd250); send(8'd100);
      chk("R1 inst load", 32'(inst_sample), 100);
      chk("R2 min", 32'(min_sample), 32'(emin));
      chk("R2 max", 32'(max_sample), 32'(emax));
      repeat (3) @(negedge clk);
      chk("R1 inst hold", 32'(inst_sample), 100);
      mm_clear = 1'b1;
      send(8'd60);
      mm_clear = 1'b0;
      emin = 8'hFF;
      emax = 8'h00;
      chk("R2 clear min", 32'(min_sample), 32'hFF);
      chk("R2 clear max", 32'(max_sample), 0);
      chk("R1 inst with clear", 32'(inst_sample), 60);
      send(8'd33);
      chk("R2 after clear min", 32'(min_sample), 33);
      chk("R2 after clear max", 32'(max_sample), 33);
      strobe("R7 flush", 1'b0, 8'd0, 1'b0, 1'b0, 0);
   endtask

   task automatic t_unsigned;
      cfg_signed = 1'b0;
      send_n(8'd200, 64);
      strobe("R3 R7 unsigned", 1'b0, 8'd0, 1'b0, 1'b0, 0);
      chk("R3 avg_pos 200", 32'(avg_pos), 200);
      chk("R3 avg_neg 0", 32'(avg_neg), 0);
      send_n(8'd255, 4000);
      strobe("R5 full scale", 1'b0, 8'd0, 1'b0, 1'b0, 0);
      chk("R5 full-scale avg", 32'(avg_pos), 15937);
      send_n(8'd9, 5);
      repeat (2) @(negedge clk);
      chk("R5 avg hold", 32'(avg_pos), 15937);
   endtask

   task automatic t_boundary;
      strobe("R6 pre", 1'b1, 8'd255, 1'b0, 1'b0, 0);
      strobe("R6 coincident sample", 1'b0, 8'd0, 1'b0, 1'b0, 0);
      chk("R6 avg from coincident 255", 32'(avg_pos), 3);
   endtask

   task automatic t_signed;
      cfg_signed = 1'b1;
      send_n(8'd200, 32);
      send_n(8'd28, 16);
      send_n(8'd128, 10);
      send(8'd129);
      strobe("R4 signed", 1'b0, 8'd0, 1'b0, 1'b0, 0);
      chk("R4 pos avg 36", 32'(avg_pos), 36);
      chk("R4 neg avg 25", 32'(avg_neg), 25);
      send_n(8'd128, 70);
      send_n(8'd127, 64);
      strobe("R4 mid code", 1'b0, 8'd0, 1'b0, 1'b0, 0);
      chk("R4 mid adds nothing", 32'(avg_pos), 0);
      chk("R4 127 negative", 32'(avg_neg), 1);
   endtask

   task automatic t_group;
      cfg_group = 1'b1;
      send_n(8'd200, 64);
      send_n(8'd0, 64);
      strobe("R8 group", 1'b0, 8'd0, 1'b0, 1'b0, 0);
      cfg_group = 1'b0;
   endtask

   task automatic t_stop;
      cfg_signed = 1'b0;
      cfg_stop = 1'b1;
      send_n(8'd255, 64);
      strobe("R9 stop", 1'b0, 8'd0, 1'b0, 1'b0, 0);
      chk("R9 avg still moves", 32'(avg_pos), 255);
      cfg_stop = 1'b0;
   endtask

   task automatic t_write_wrap;
      tot_wr_pos = 1'b1;
      tot_wr_data = 32'hFFFF_FFF0;
      @(negedge clk);
      tot_wr_pos = 1'b0;
      tp = 32'hFFFF_FFF0;
      chk("R10 write pos", tot_pos, tp);
      tot_wr_neg = 1'b1;
      tot_wr_data = 32'd5;
      @(negedge clk);
      tot_wr_neg = 1'b0;
      tn = 32'd5;
      chk("R10 write neg", tot_neg, 5);
      send_n(8'd200, 64);
      strobe("R11 wrap", 1'b0, 8'd0, 1'b0, 1'b0, 0);
      chk("R11 wrapped total", tot_pos, 184);
      send_n(8'd100, 64);
      strobe("R10 write wins", 1'b0, 8'd0, 1'b1, 1'b0, 32'h0000_1234);
      chk("R10 priority", tot_pos, 32'h1234);
      chk("R10 avg unaffected", 32'(avg_pos), 100);
   endtask

   initial begin
      t_reset;
      t_minmax;
      t_unsigned;
      t_boundary;
      t_signed;
      t_group;
      t_stop;
      t_write_wrap;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule